// File: doc/BRIEF.md
# Packet Self-Test Result Checker

This block judges a packet self-test run. While a run is active, each received data word that comes with a valid strobe is compared with the word that the pattern generator expects at that moment. The block keeps a pass/fail verdict and an 8-bit count of mismatched words. It also holds a continuous-transmit enable that tells the transmit side to keep sending pattern data without a break.

Software drives the block through two write strobes. The run write sets or clears the run bit. It also starts a fresh result, which means the verdict goes back to fail and the count goes back to zero. The continuous write sets the continuous-transmit enable and leaves the results alone.

The verdict starts at fail. It becomes pass after a good comparison. After any mismatch it stays at fail until the next run write.

Top module: `bist_result_checker`

## Requirements
- R1: Reset is synchronous and active high. While it is held, and after it is released, `bist_pass` is 0, `err_cnt` is 0 and `cont_en` is 0. The run bit is also cleared by reset.
- R2: A comparison takes place only in a cycle where the run bit is 1 and `rx_valid` is 1. In any other cycle, `rx_data` and `exp_data` have no effect on `bist_pass` or `err_cnt`.
- R3: A comparison matches when all `DATA_W` bits of `rx_data` equal `exp_data`. A match drives `bist_pass` to 1 one clock later, unless an error is latched.
- R4: A comparison with any differing bit drives `bist_pass` to 0 one clock later. The error is then latched, and later matches leave `bist_pass` at 0 until the next run write.
- R5: Each mismatch raises `err_cnt` by exactly one, visible one clock later.
- R6: `err_cnt` saturates at 255 and never wraps to 0 on further mismatches.
- R7: A run write (`run_wr`=1, with either value of `run_val`) clears `err_cnt` to 0, `bist_pass` to 0 and the latched error one clock later. A comparison in that same cycle is discarded.
- R8: A run write loads `run_val` into the run bit. While the run bit is 0, no comparison takes place.
- R9: A continuous write (`cont_wr`=1) loads `cont_val` into `cont_en` one clock later. It does not change `bist_pass`, `err_cnt` or the run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_wr | input | 1 | Write strobe for the run bit; also clears the results |
| run_val | input | 1 | Value for the run bit (1 starts a run, 0 stops it) |
| cont_wr | input | 1 | Write strobe for the continuous-transmit enable |
| cont_val | input | 1 | Value for the continuous-transmit enable |
| rx_valid | input | 1 | Received word is valid this cycle |
| rx_data | input | DATA_W | Received data word |
| exp_data | input | DATA_W | Expected word from the pattern generator |
| bist_pass | output | 1 | 1 = run passing, 0 = fail or no result yet |
| err_cnt | output | 8 | Saturating mismatch count |
| cont_en | output | 1 | Continuous-transmit enable |

## Verification
Every result is registered once, so a stimulus applied in the cycle before a rising edge shows up on `bist_pass`, `err_cnt` or `cont_en` right after that edge. The run bit itself gates comparisons from the cycle after its write. The bench therefore drives each vector on a falling edge and reads the outputs on the next falling edge, which makes each check exactly one edge after its stimulus. For the run-bit gating, the vector that follows a run write is the first one expected to be compared or ignored.

// File: rtl/bist_chk_pkg.sv
package bist_chk_pkg;

    localparam int CNT_W = 8;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef enum logic [1:0] {
        ST_FAIL = 2'd0,
        ST_PASS = 2'd1,
        ST_ERR  = 2'd2
    } verdict_e;

    typedef struct packed {
        logic hit;
        logic miss;
    } cmp_res_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/bist_ctrl_regs.sv
module bist_ctrl_regs (
    input  logic clk,
    input  logic rst,
    input  logic run_wr,
    input  logic run_val,
    input  logic cont_wr,
    input  logic cont_val,
    output logic run_q,
    output logic cont_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            cont_q <= 1'b0;
        end else begin
            if (run_wr)  run_q  <= run_val;
            if (cont_wr) cont_q <= cont_val;
        end
    end

    assert_cont_load_R9: assert property (@(posedge clk) disable iff (rst)
        cont_wr |=> (cont_q == $past(cont_val)));

    assert_run_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !run_wr |=> $stable(run_q));
endmodule

// File: rtl/bist_compare.sv
module bist_compare
    import bist_chk_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              run,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [DATA_W-1:0] exp_data,
    output cmp_res_t          res
);
    logic [DATA_W-1:0] diff;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign diff[i] = rx_data[i] ^ exp_data[i];
    end

    logic active;
    assign active = run & rx_valid;

    always_comb begin
        res.hit  = active & ~(|diff);
        res.miss = active &  (|diff);
    end

    always_comb begin
        assert_cmp_excl_R3: assert (!(res.hit && res.miss));
    end
endmodule

// File: rtl/bist_result.sv
module bist_result
    import bist_chk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  cmp_res_t         cmp,
    output verdict_e         verdict,
    output logic [CNT_W-1:0] cnt
);
    verdict_e         verdict_d;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        verdict_d = verdict;
        cnt_d     = cnt;
        if (clr) begin
            verdict_d = ST_FAIL;
            cnt_d     = '0;
        end else if (cmp.miss) begin
            verdict_d = ST_ERR;
            cnt_d     = sat_inc(cnt);
        end else if (cmp.hit && verdict != ST_ERR) begin
            verdict_d = ST_PASS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict <= ST_FAIL;
            cnt     <= '0;
        end else begin
            verdict <= verdict_d;
            cnt     <= cnt_d;
        end
    end

    assert_err_latch_R4: assert property (@(posedge clk) disable iff (rst)
        (verdict == ST_ERR && !clr) |=> (verdict == ST_ERR));

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    assert_cnt_sat_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0 && verdict == ST_FAIL));

    assert_pass_on_hit_R3: assert property (@(posedge clk) disable iff (rst)
        (cmp.hit && !clr && verdict != ST_ERR) |=> (verdict == ST_PASS));
endmodule

// File: rtl/bist_result_checker.sv
module bist_result_checker
    import bist_chk_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_wr,
    input  logic              run_val,
    input  logic              cont_wr,
    input  logic              cont_val,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [DATA_W-1:0] exp_data,
    output logic              bist_pass,
    output logic [CNT_W-1:0]  err_cnt,
    output logic              cont_en
);
    logic     run_q;
    cmp_res_t cmp;
    verdict_e verdict;

    bist_ctrl_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .run_wr   (run_wr),
        .run_val  (run_val),
        .cont_wr  (cont_wr),
        .cont_val (cont_val),
        .run_q    (run_q),
        .cont_q   (cont_en)
    );

    bist_compare #(.DATA_W(DATA_W)) u_cmp (
        .run      (run_q),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .exp_data (exp_data),
        .res      (cmp)
    );

    bist_result u_res (
        .clk     (clk),
        .rst     (rst),
        .clr     (run_wr),
        .cmp     (cmp),
        .verdict (verdict),
        .cnt     (err_cnt)
    );

    assign bist_pass = (verdict == ST_PASS);

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!(run_q && rx_valid) && !run_wr) |=> ($stable(err_cnt) && $stable(bist_pass)));

    assert_stopped_R8: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !run_wr) |=> ($stable(err_cnt) && $stable(bist_pass)));
endmodule

// File: tb/bist_result_checker_tb.sv
module bist_result_checker_tb;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run_wr = 0, run_val = 0, cont_wr = 0, cont_val = 0, rx_valid = 0;
    logic [DW-1:0] rx_data = '0, exp_data = '0;
    logic          bist_pass;
    logic [7:0]    err_cnt;
    logic          cont_en;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bist_result_checker #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .run_wr(run_wr), .run_val(run_val),
        .cont_wr(cont_wr), .cont_val(cont_val), .rx_valid(rx_valid),
        .rx_data(rx_data), .exp_data(exp_data),
        .bist_pass(bist_pass), .err_cnt(err_cnt), .cont_en(cont_en)
    );

    typedef struct packed {
        logic         rw, rv, cw, cv, vld;
        logic [DW-1:0] rxd, exd;
        logic         e_pass;
        logic [7:0]   e_cnt;
        logic         e_cont;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,8'd0,1'b0}, // R7 R8 start run
        '{1'b0,1'b0,1'b0,1'b0,1'b1,4'h5,4'h5,1'b1,8'd0,1'b0}, // R3 match
        '{1'b0,1'b0,1'b0,1'b0,1'b1,4'hA,4'hA,1'b1,8'd0,1'b0}, // R3 match
        '{1'b0,1'b0,1'b0,1'b0,1'b0,4'h1,4'h2,1'b1,8'd0,1'b0}, // R2 not valid
        '{1'b0,1'b0,1'b0,1'b0,1'b1,4'h3,4'h2,1'b0,8'd1,1'b0}, // R4 R5 mismatch
        '{1'b0,1'b0,1'b0,1'b0,1'b1,4'h7,4'h7,1'b0,8'd1,1'b0}, // R4 stays latched
        '{1'b0,1'b0,1'b0,1'b0,1'b1,4'h8,4'h9,1'b0,8'd2,1'b0}, // R5 second miss
        '{1'b0,1'b0,1'b1,1'b1,1'b0,4'h0,4'h0,1'b0,8'd2,1'b1}, // R9 cont on
        '{1'b1,1'b1,1'b0,1'b0,1'b1,4'h1,4'h0,1'b0,8'd0,1'b1}, // R7 discard
        '{1'b0,1'b0,1'b0,1'b0,1'b1,4'h4,4'h4,1'b1,8'd0,1'b1}, // R3 R9 run still on
        '{1'b1,1'b0,1'b0,1'b0,1'b0,4'h0,4'h0,1'b0,8'd0,1'b1}, // R7 R8 stop
        '{1'b0,1'b0,1'b0,1'b0,1'b1,4'h1,4'h2,1'b0,8'd0,1'b1}, // R8 ignored
        '{1'b0,1'b0,1'b0,1'b0,1'b1,4'h6,4'h6,1'b0,8'd0,1'b1}, // R8 ignored
        '{1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,4'h0,1'b0,8'd0,1'b0}  // R9 cont off
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        run_wr = 0; run_val = 0; cont_wr = 0; cont_val = 0; rx_valid = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 pass in reset", {7'd0, bist_pass}, 8'd0);
        check("R1 cnt in reset", err_cnt, 8'd0);
        rst = 0;
        @(negedge clk);
        check("R1 cont after reset", {7'd0, cont_en}, 8'd0);
        for (int i = 0; i < NV; i++) begin
            run_wr = VECS[i].rw; run_val = VECS[i].rv;
            cont_wr = VECS[i].cw; cont_val = VECS[i].cv;
            rx_valid = VECS[i].vld; rx_data = VECS[i].rxd; exp_data = VECS[i].exd;
            @(negedge clk);
            check($sformatf("vec%0d pass", i), {7'd0, bist_pass}, {7'd0, VECS[i].e_pass});
            check($sformatf("vec%0d cnt", i), err_cnt, VECS[i].e_cnt);
            check($sformatf("vec%0d cont", i), {7'd0, cont_en}, {7'd0, VECS[i].e_cont});
        end
        idle();

        // R6 saturation: start a run, then 260 mismatches
        run_wr = 1; run_val = 1;
        @(negedge clk);
        idle();
        rx_valid = 1; rx_data = 4'hF; exp_data = 4'h0;
        for (int k = 1; k <= 260; k++) begin
            @(negedge clk);
            if (k == 1)   check("R5 first miss", err_cnt, 8'd1);
            if (k == 255) check("R6 reach max", err_cnt, 8'd255);
            if (k == 260) check("R6 no wrap", err_cnt, 8'd255);
        end
        rx_data = 4'h0;
        @(negedge clk);
        check("R4 match after sat", {7'd0, bist_pass}, 8'd0);
        idle();
        run_wr = 1; run_val = 1;
        @(negedge clk);
        idle();
        check("R7 clear after sat", err_cnt, 8'd0);

        // R1 reset mid-run
        cont_wr = 1; cont_val = 1; rx_valid = 1; rx_data = 4'h2; exp_data = 4'h2;
        @(negedge clk);
        check("R3 pass before reset", {7'd0, bist_pass}, 8'd1);
        idle();
        rst = 1;
        @(negedge clk);
        check("R1 pass on reset", {7'd0, bist_pass}, 8'd0);
        check("R1 cont on reset", {7'd0, cont_en}, 8'd0);
        rst = 0;
        // run bit cleared by reset: comparisons ignored
        rx_valid = 1; rx_data = 4'h1; exp_data = 4'h3;
        @(negedge clk);
        check("R1 run cleared", err_cnt, 8'd0);
        idle();
        summary();
    end
endmodule